// File: doc/BRIEF.md
# DSP Branch and Pointer Update Unit

This block holds the program counter and the data pointer of a small fixed-point DSP. It chooses the next program counter value, and it applies the pointer step that ALU instructions ask for.

On a branch instruction it decodes a 9-bit condition code and tests it against several sources: the flags of the two accumulators, the low nibble of the data pointer and the host request flag. When the condition holds, the counter loads a bank-relative target. The top counter bit is kept, and the bank and the 11-bit offset come from the instruction. One code jumps unconditionally to an address held in the serial-output register. Any other instruction advances the counter by one.

On a non-branch instruction the data pointer can be loaded, and its low nibble can be stepped up, stepped down or cleared. The step wraps inside the nibble and leaves the upper pointer bits alone. The return stack and instruction fetch sit in neighbouring blocks.

Top module: `dsp_next_pc`

## Requirements
- R1: While `rst_n` is low, the next clock edge sets `pc` and `dp` to zero.
- R2: With `op_valid` low, `pc` and `dp` keep their values. A branch instruction (`op_valid` and `op_is_jump` high) never changes `dp`.
- R3: A non-branch instruction and a branch that is not taken both set `pc` to `pc`+1, wrapping from 0x3FFF to 0x0000.
- R4: A taken branch other than code 0x000 loads `pc` with {old `pc`[13], `bank`[1:0], `target`[10:0]}.
- R5: Code 0x000 is always taken and loads `pc` with `so_addr`.
- R6: Flag codes run from 0x080 to 0x0AE in even steps. Code = 0x080 + 8*f + 2*k, where f selects the flag bit in `flags_a`/`flags_b`: bit 0 carry, 1 zero, 2 overflow 0, 3 overflow 1, 4 sign 0, 5 sign 1. The value of k picks the test: k=0 means A bit is 0, k=1 means A bit is 1, k=2 means B bit is 0, k=3 means B bit is 1.
- R7: Codes 0x0B0, 0x0B1, 0x0B2 and 0x0B3 are taken when `dp`[3:0] is 0, is not 0, is 0xF, and is not 0xF, respectively.
- R8: Code 0x0BC is taken when `rqm` is 0, and code 0x0BE is taken when `rqm` is 1.
- R9: The serial acknowledge codes 0x0B4, 0x0B6, 0x0B8 and 0x0BA are never taken. Neither is any other code not listed in R5 to R8, such as 0x081 or 0x1FF.
- R10: On a non-branch instruction, `dp_mod` sets the step: 0 keeps the nibble, 1 adds one to `dp`[3:0], 2 subtracts one, and 3 clears it. The nibble wraps modulo 16, and `dp`[DPW-1:4] is unchanged.
- R11: On a non-branch instruction with `dp_ld` high, `dp` takes `dp_ld_val`, and the `dp_mod` step applies to that loaded value in the same cycle.
- R12: `taken` is high in the cycle where a valid branch instruction meets its condition, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An instruction executes this cycle |
| op_is_jump | input | 1 | The instruction is a branch |
| cond | input | 9 | Branch condition code |
| target | input | NAW (11) | Branch offset within the bank |
| bank | input | BKW (2) | Branch bank |
| so_addr | input | 14 | Serial-output register value used by code 0x000 |
| flags_a | input | 6 | Accumulator A flags (C, Z, OV0, OV1, S0, S1 at bits 0..5) |
| flags_b | input | 6 | Accumulator B flags, same layout |
| rqm | input | 1 | Host request flag |
| dp_ld | input | 1 | Load the data pointer |
| dp_ld_val | input | DPW (8) | Value to load |
| dp_mod | input | 2 | Low-nibble step: none, increment, decrement, clear |
| pc | output | 14 | Program counter |
| dp | output | DPW (8) | Data pointer |
| taken | output | 1 | The branch this cycle is taken |

## Verification
A pointer load and a nibble step can happen in the same instruction. The bench provokes this by loading values whose nibble sits at 0xF or 0x0 and stepping across the wrap in that same cycle. It judges the result by checking that the upper bits come from the loaded value and the nibble shows the stepped, wrapped result. The counter update and the pointer nibble tests also meet: a pointer step in one instruction feeds the nibble branch in the next. The bench runs such pairs back to back and checks each branch against the pointer value it has just predicted.

// File: rtl/dsp_next_pc.sv
module dsp_next_pc #(
  parameter int NAW = 11,
  parameter int BKW = 2,
  parameter int DPW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic                 op_is_jump,
  input  logic [8:0]           cond,
  input  logic [NAW-1:0]       target,
  input  logic [BKW-1:0]       bank,
  input  logic [NAW+BKW:0]     so_addr,
  input  logic [5:0]           flags_a,
  input  logic [5:0]           flags_b,
  input  logic                 rqm,
  input  logic                 dp_ld,
  input  logic [DPW-1:0]       dp_ld_val,
  input  logic [1:0]           dp_mod,
  output logic [NAW+BKW:0]     pc,
  output logic [DPW-1:0]       dp,
  output logic                 taken
);
  localparam int PCW = NAW + BKW + 1;

  logic [5:0]     fsel;
  logic           hit;
  logic [3:0]     nib;
  logic [DPW-1:0] dp_base, dp_next;
  logic [PCW-1:0] pc_next;

  assign nib  = dp[3:0];
  assign fsel = cond[2] ? flags_b : flags_a;

  always_comb begin
    hit = 1'b0;
    if (cond == 9'h000)
      hit = 1'b1;
    else if (cond[8:6] == 3'b010 && !cond[0] && cond[5:4] != 2'b11)
      hit = (fsel[cond[5:3]] == cond[1]);
    else if (cond[8:2] == 7'b0101100)
      case (cond[1:0])
        2'd0:    hit = (nib == 4'h0);
        2'd1:    hit = (nib != 4'h0);
        2'd2:    hit = (nib == 4'hF);
        default: hit = (nib != 4'hF);
      endcase
    else if (cond == 9'h0BC)
      hit = !rqm;
    else if (cond == 9'h0BE)
      hit = rqm;
  end

  assign taken = op_valid && op_is_jump && hit;

  always_comb begin
    if (taken)
      pc_next = (cond == 9'h000) ? so_addr : {pc[PCW-1], bank, target};
    else
      pc_next = pc + 1'b1;
  end

  assign dp_base = dp_ld ? dp_ld_val : dp;

  always_comb begin
    case (dp_mod)
      2'd1:    dp_next = {dp_base[DPW-1:4], dp_base[3:0] + 4'd1};
      2'd2:    dp_next = {dp_base[DPW-1:4], dp_base[3:0] - 4'd1};
      2'd3:    dp_next = {dp_base[DPW-1:4], 4'h0};
      default: dp_next = dp_base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      dp <= '0;
    end else if (op_valid) begin
      pc <= pc_next;
      if (!op_is_jump) dp <= dp_next;
    end
  end
endmodule

// File: rtl/dsp_next_pc_chk.sv
module dsp_next_pc_chk #(
  parameter int NAW = 11,
  parameter int BKW = 2,
  parameter int DPW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic               op_is_jump,
  input logic [8:0]         cond,
  input logic [NAW-1:0]     target,
  input logic [BKW-1:0]     bank,
  input logic               dp_ld,
  input logic [NAW+BKW:0]   pc,
  input logic [DPW-1:0]     dp,
  input logic               taken
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (pc == '0 && dp == '0));

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(pc) && $stable(dp)));

  assert_jump_keeps_dp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_is_jump) |=> $stable(dp));

  assert_untaken_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !taken) |=> pc == $past(pc) + 1'b1);

  assert_bank_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && cond != 9'h000) |=>
      (pc[NAW+BKW] == $past(pc[NAW+BKW]) && pc[NAW+BKW-1:0] == {$past(bank), $past(target)}));

  assert_serial_never_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 9'h0B4 || cond == 9'h0B6 || cond == 9'h0B8 || cond == 9'h0BA) |-> !taken);

  assert_upper_dp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_is_jump && !dp_ld) |=> dp[DPW-1:4] == $past(dp[DPW-1:4]));

  assert_taken_needs_jump_R12: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (op_valid && op_is_jump));
endmodule

bind dsp_next_pc dsp_next_pc_chk #(.NAW(NAW), .BKW(BKW), .DPW(DPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_jump(op_is_jump),
  .cond(cond), .target(target), .bank(bank), .dp_ld(dp_ld),
  .pc(pc), .dp(dp), .taken(taken)
);

// File: tb/tb_dsp_next_pc.sv
module tb_dsp_next_pc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_is_jump = 1'b0;
  logic [8:0]  cond = '0;
  logic [10:0] target = '0;
  logic [1:0]  bank = '0;
  logic [13:0] so_addr = '0;
  logic [5:0]  flags_a = '0, flags_b = '0;
  logic        rqm = 1'b0, dp_ld = 1'b0;
  logic [7:0]  dp_ld_val = '0;
  logic [1:0]  dp_mod = '0;
  logic [13:0] pc;
  logic [7:0]  dp;
  logic        taken;

  int checks = 0, errors = 0;
  logic [13:0] exp_pc = '0;
  logic [7:0]  exp_dp = '0;

  dsp_next_pc dut (.*);

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_jump(string tag, logic [8:0] c, logic [1:0] bk, logic [10:0] tg, logic exp_t);
    @(negedge clk);
    op_valid = 1; op_is_jump = 1; cond = c; bank = bk; target = tg;
    dp_ld = 0; dp_mod = 2'd1;
    #1 check({tag, " R12 taken"}, taken, exp_t);
    @(posedge clk); #1;
    if (exp_t) exp_pc = (c == 9'h000) ? so_addr : {exp_pc[13], bk, tg};
    else       exp_pc = exp_pc + 14'd1;
    check({tag, " pc"}, pc, exp_pc);
    check({tag, " R2 dp on jump"}, dp, exp_dp);
  endtask

  task automatic do_alu(string tag, logic ld, logic [7:0] v, logic [1:0] m);
    logic [7:0] b;
    @(negedge clk);
    op_valid = 1; op_is_jump = 0; cond = 9'h000; dp_ld = ld; dp_ld_val = v; dp_mod = m;
    #1 check({tag, " R12 no taken"}, taken, 0);
    @(posedge clk); #1;
    b = ld ? v : exp_dp;
    case (m)
      2'd1: b[3:0] = b[3:0] + 4'd1;
      2'd2: b[3:0] = b[3:0] - 4'd1;
      2'd3: b[3:0] = 4'd0;
      default: ;
    endcase
    exp_dp = b;
    exp_pc = exp_pc + 14'd1;
    check({tag, " R3 pc"}, pc, exp_pc);
    check({tag, " dp"}, dp, exp_dp);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 check("R1 reset pc", pc, 0);
    check("R1 reset dp", dp, 0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_idle;
    @(negedge clk);
    op_valid = 0; op_is_jump = 1; cond = 9'h000; dp_ld = 1; dp_mod = 2'd3;
    repeat (3) @(posedge clk);
    #1 check("R2 idle pc", pc, exp_pc);
    check("R2 idle dp", dp, exp_dp);
    check("R12 idle taken", taken, 0);
  endtask

  task automatic t_dp;
    do_alu("R10 none", 0, 0, 2'd0);
    do_alu("R11 load+inc wrap", 1, 8'h5F, 2'd1);
    check("R11 dp value", dp, 8'h50);
    do_alu("R10 dec wrap", 0, 0, 2'd2);
    check("R10 dec value", dp, 8'h5F);
    do_alu("R10 clear", 0, 0, 2'd3);
    check("R10 clear value", dp, 8'h50);
    do_alu("R11 load+dec wrap", 1, 8'hA0, 2'd2);
    check("R11 dp value 2", dp, 8'hAF);
    do_alu("R11 load only", 1, 8'h3E, 2'd0);
    do_alu("R10 inc", 0, 0, 2'd1);
    check("R10 inc value", dp, 8'h3F);
  endtask

  task automatic t_flags;
    logic [5:0] pa [4];
    logic [5:0] pb [4];
    for (int f = 0; f < 6; f++) begin
      pa[0] = 6'h00; pb[0] = 6'h00;
      pa[1] = 6'h3F; pb[1] = 6'h3F;
      pa[2] = 6'h01 << f; pb[2] = 6'h00;
      pa[3] = 6'h00; pb[3] = 6'h01 << f;
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 4; k++) begin
          logic bitv;
          flags_a = pa[p]; flags_b = pb[p];
          bitv = (k < 2) ? pa[p][f] : pb[p][f];
          do_jump("R6 flag", 9'h080 + 9'(8*f + 2*k), 2'(k), 11'(f*100 + p*10 + k), bitv == k[0]);
        end
    end
    flags_a = 0; flags_b = 0;
  endtask

  task automatic t_nibble;
    do_alu("R7 setup 0", 1, 8'h70, 2'd0);
    do_jump("R7 eq0", 9'h0B0, 0, 11'h011, 1);
    do_jump("R7 ne0", 9'h0B1, 0, 11'h012, 0);
    do_jump("R7 eqF", 9'h0B2, 0, 11'h013, 0);
    do_jump("R7 neF", 9'h0B3, 0, 11'h014, 1);
    do_alu("R7 step to F", 0, 0, 2'd2);
    do_jump("R7 eq0 F", 9'h0B0, 0, 11'h021, 0);
    do_jump("R7 ne0 F", 9'h0B1, 0, 11'h022, 1);
    do_jump("R7 eqF F", 9'h0B2, 0, 11'h023, 1);
    do_jump("R7 neF F", 9'h0B3, 0, 11'h024, 0);
    do_alu("R7 step to 0", 0, 0, 2'd1);
    do_jump("R7 eq0 again", 9'h0B0, 0, 11'h031, 1);
  endtask

  task automatic t_rqm;
    rqm = 0;
    do_jump("R8 nrqm lo", 9'h0BC, 1, 11'h055, 1);
    do_jump("R8 rqm lo", 9'h0BE, 1, 11'h056, 0);
    rqm = 1;
    do_jump("R8 nrqm hi", 9'h0BC, 1, 11'h057, 0);
    do_jump("R8 rqm hi", 9'h0BE, 1, 11'h058, 1);
  endtask

  task automatic t_never;
    flags_a = 6'h3F; flags_b = 6'h00; rqm = 1;
    do_jump("R9 serial B4", 9'h0B4, 2, 11'h100, 0);
    do_jump("R9 serial B6", 9'h0B6, 2, 11'h101, 0);
    do_jump("R9 serial B8", 9'h0B8, 2, 11'h102, 0);
    do_jump("R9 serial BA", 9'h0BA, 2, 11'h103, 0);
    do_jump("R9 odd 081", 9'h081, 2, 11'h104, 0);
    do_jump("R9 code 1FF", 9'h1FF, 2, 11'h105, 0);
    do_jump("R9 code 0B0+100", 9'h1B0, 2, 11'h106, 0);
    flags_a = 0;
  endtask

  task automatic t_so_and_top;
    so_addr = 14'h2ABC;
    do_jump("R5 so jump", 9'h000, 3, 11'h7FF, 1);
    flags_a = 6'h01;
    do_jump("R4 top bit kept", 9'h082, 1, 11'h123, 1);
    check("R4 pc value", pc, 14'h2923);
    so_addr = 14'h3FFF;
    do_jump("R5 so to end", 9'h000, 0, 0, 1);
    do_alu("R3 wrap", 0, 0, 2'd0);
    check("R3 wrap value", pc, 14'h0000);
    flags_a = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_dp();
    t_flags();
    t_nibble();
    t_rqm();
    t_never();
    t_so_and_top();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule